// File: doc/BRIEF.md
# Command/Data Port Register Bridge

This block sits between a host and an external controller that has only two 16-bit ports: a command port and a data port. The host asks for a register read or a register write. The bridge first writes a command word to the command port. That word carries the register offset and a pair of byte-enable bits, and the pair sits in the upper or the lower half of the top nibble depending on offset bit 1. The bridge then makes exactly one access to the data port.

Queue traffic uses block mode instead. A block request skips the command phase and streams half the byte length, in 16-bit words, through the data port. Write words are pulled from the host one at a time. Read words are handed back with a valid pulse.

Each port access is one strobe cycle followed by one quiet cycle. Strobes therefore never touch, and a port-select output says which port the current strobe addresses.

Top module: `cmd_data_bridge`

## Requirements
- R1: While reset is high and after it, until a request is accepted, `req_ready` is 1 and `bus_stb`, `done`, `rd_valid` and `wr_next` are 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. A `req_valid` raised while the bridge is busy leaves every output unchanged.
- R3: `req_op` encodes 00 = register read, 01 = register write, 10 = block read, 11 = block write. For a register access with offset bit 1 clear, the command word is the offset with bit 0 forced to 0, ORed with 0x3000 (enables at bits 13:12).
- R4: For a register access with offset bit 1 set, the enables move to bits 15:14, so the command word is the offset with bit 0 cleared, ORed with 0xC000.
- R5: Register read: the cycle after acceptance carries a command strobe (`bus_sel`=1, `bus_we`=1). Then comes one quiet cycle, then a data strobe (`bus_sel`=0, `bus_we`=0). In the next cycle `rd_data` holds the `bus_rdata` seen during that strobe, and `rd_valid` and `done` are 1.
- R6: Register write: same cadence as R5, but the data strobe has `bus_we`=1 and `bus_wdata` equal to the `req_wdata` captured at acceptance. `rd_valid` stays 0.
- R7: A block request makes `req_len`>>1 data strobes (`bus_sel`=0) and no command strobe. The first comes the cycle after acceptance, and each later one comes two cycles after the one before.
- R8: Block write: word 0 is the `req_wdata` at acceptance. After every strobe except the last, `wr_next` is 1 in the quiet cycle, and the next word is the `req_wdata` present at the end of that cycle.
- R9: Block read: after each strobe, `rd_valid` is 1 for one cycle and `rd_data` holds the `bus_rdata` sampled during that strobe.
- R10: An odd `req_len` is rounded down. A length below 2 gives no strobe and raises `done` the cycle after acceptance.
- R11: `bus_stb` is never 1 in two consecutive cycles.
- R12: `done` is a one-cycle pulse in the cycle after the last data strobe (for R10, the cycle after acceptance). `req_ready` is 1 in that same cycle, so a new request may be taken at its closing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation code (see R3) |
| req_offset | input | OFFS_W | Register byte offset |
| req_wdata | input | 16 | Register write value, or the current block write word |
| req_len | input | LEN_W | Block length in bytes |
| req_ready | output | 1 | Bridge idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last word read from the data port |
| rd_valid | output | 1 | `rd_data` holds a new word |
| wr_next | output | 1 | Present the next block write word before the coming edge |
| bus_stb | output | 1 | Port access strobe |
| bus_sel | output | 1 | 1 = command port, 0 = data port |
| bus_we | output | 1 | Strobe is a write |
| bus_wdata | output | 16 | Word written by the strobe |
| bus_rdata | input | 16 | Word returned by the data port, sampled at the end of a read strobe |

## Verification
If a request is accepted at the edge closing cycle c, the command strobe of a register access is due in cycle c+1. Its data strobe is due in c+3, and `done` with read data in c+4. Block word k strobes in cycle c+1+2k, and its `rd_valid` or `wr_next` follows one cycle later. The bench logs every expected output against the absolute cycle number when it issues the request. It drives inputs and compares outputs on the falling edge, so each value is read in the middle of the cycle it belongs to. The data port returns a word computed from the cycle number, which makes any read captured one cycle early or late show up as a wrong value.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  localparam int PORT_W = 16;
  localparam int BE_LSB = 12;

  typedef enum logic [1:0] {
    OP_REG_RD = 2'b00,
    OP_REG_WR = 2'b01,
    OP_BLK_RD = 2'b10,
    OP_BLK_WR = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_CMD_GAP,
    S_DAT,
    S_DAT_GAP
  } st_e;
endpackage

// File: rtl/cdb_cmd_fmt.sv
module cdb_cmd_fmt
  import cdb_pkg::*;
#(
  parameter int OFFS_W = 8
) (
  input  logic [OFFS_W-1:0] offs,
  output logic [PORT_W-1:0] cmd_word
);
  localparam logic [PORT_W-1:0] EVEN_MASK = ~PORT_W'(1);
  logic [PORT_W-1:0] base;
  logic [PORT_W-1:0] be_bits;

  always_comb begin
    base    = PORT_W'(offs) & EVEN_MASK;
    // Enable pair shifts up by two when the offset targets the upper half-word
    be_bits = PORT_W'(2'b11) << (BE_LSB + (offs[1] ? 2 : 0));
    cmd_word = base | be_bits;
  end
endmodule

// File: rtl/cdb_word_cnt.sv
module cdb_word_cnt #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] len_bytes,
  input  logic             load,
  input  logic             dec,
  output logic             zero_len,
  output logic             last
);
  logic [LEN_W-1:0] words;
  logic [LEN_W-1:0] left;

  assign words    = len_bytes >> 1;
  assign zero_len = (words == '0);
  assign last     = (left == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst)       left <= '0;
    else if (load) left <= words;
    else if (dec)  left <= left - LEN_W'(1);
  end
endmodule

// File: rtl/cdb_seq.sv
module cdb_seq
  import cdb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  op_e               op,
  input  logic [PORT_W-1:0] cmd_word,
  input  logic [PORT_W-1:0] req_wdata,
  input  logic              cnt_zero,
  input  logic              cnt_last,
  output logic              cnt_load,
  output logic              cnt_dec,
  output logic              cap_en,
  output logic              ready,
  output logic              done,
  output logic              rd_valid,
  output logic              wr_next,
  output logic              stb,
  output logic              sel,
  output logic              we,
  output logic [PORT_W-1:0] wdata
);
  st_e               st;
  op_e               op_q;
  logic [PORT_W-1:0] hold;
  logic              is_reg_q;

  assign ready    = (st == S_IDLE);
  assign cnt_load = ready && req_valid;
  assign cnt_dec  = (st == S_DAT);
  assign cap_en   = (st == S_DAT) && !we;
  assign is_reg_q = (op_q == OP_REG_RD) || (op_q == OP_REG_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      op_q     <= OP_REG_RD;
      hold     <= '0;
      stb      <= 1'b0;
      sel      <= 1'b0;
      we       <= 1'b0;
      wdata    <= '0;
      done     <= 1'b0;
      rd_valid <= 1'b0;
      wr_next  <= 1'b0;
    end else begin
      stb      <= 1'b0;
      done     <= 1'b0;
      rd_valid <= 1'b0;
      wr_next  <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (req_valid) begin
            op_q <= op;
            hold <= req_wdata;
            if (op == OP_REG_RD || op == OP_REG_WR) begin
              stb   <= 1'b1;
              sel   <= 1'b1;
              we    <= 1'b1;
              wdata <= cmd_word;
              st    <= S_CMD;
            end else if (cnt_zero) begin
              done <= 1'b1;
            end else begin
              stb   <= 1'b1;
              sel   <= 1'b0;
              we    <= (op == OP_BLK_WR);
              wdata <= req_wdata;
              st    <= S_DAT;
            end
          end
        end
        S_CMD: st <= S_CMD_GAP;
        S_CMD_GAP: begin
          stb   <= 1'b1;
          sel   <= 1'b0;
          we    <= (op_q == OP_REG_WR);
          wdata <= hold;
          st    <= S_DAT;
        end
        S_DAT: begin
          rd_valid <= !we;
          if (is_reg_q || cnt_last) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            wr_next <= we;
            st      <= S_DAT_GAP;
          end
        end
        S_DAT_GAP: begin
          stb   <= 1'b1;
          wdata <= req_wdata;
          st    <= S_DAT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_data_bridge.sv
module cmd_data_bridge
  import cdb_pkg::*;
#(
  parameter int OFFS_W = 8,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [OFFS_W-1:0] req_offset,
  input  logic [15:0]       req_wdata,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  output logic              done,
  output logic [15:0]       rd_data,
  output logic              rd_valid,
  output logic              wr_next,
  output logic              bus_stb,
  output logic              bus_sel,
  output logic              bus_we,
  output logic [15:0]       bus_wdata,
  input  logic [15:0]       bus_rdata
);
  logic [PORT_W-1:0] cmd_word;
  logic cnt_zero, cnt_last, cnt_load, cnt_dec, cap_en;

  cdb_cmd_fmt #(.OFFS_W(OFFS_W)) u_fmt (
    .offs     (req_offset),
    .cmd_word (cmd_word)
  );

  cdb_word_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .len_bytes (req_len),
    .load      (cnt_load),
    .dec       (cnt_dec),
    .zero_len  (cnt_zero),
    .last      (cnt_last)
  );

  cdb_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .op        (op_e'(req_op)),
    .cmd_word  (cmd_word),
    .req_wdata (req_wdata),
    .cnt_zero  (cnt_zero),
    .cnt_last  (cnt_last),
    .cnt_load  (cnt_load),
    .cnt_dec   (cnt_dec),
    .cap_en    (cap_en),
    .ready     (req_ready),
    .done      (done),
    .rd_valid  (rd_valid),
    .wr_next   (wr_next),
    .stb       (bus_stb),
    .sel       (bus_sel),
    .we        (bus_we),
    .wdata     (bus_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (cap_en) rd_data <= bus_rdata;
  end
endmodule

// File: rtl/cdb_sva.sv
module cdb_sva (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic done,
  input logic rd_valid,
  input logic wr_next,
  input logic bus_stb,
  input logic bus_sel,
  input logic bus_we
);
  a_r11_strobe_gap: assert property (@(posedge clk) disable iff (rst)
    bus_stb |=> !bus_stb);

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r12_ready_with_done: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !bus_stb);

  a_r5_cmd_then_data: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && bus_sel) |=> !bus_stb ##1 (bus_stb && !bus_sel));

  a_r9_rdvalid_after_read: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_stb && !bus_sel && !bus_we));

  a_r8_wrnext_after_write: assert property (@(posedge clk) disable iff (rst)
    wr_next |-> $past(bus_stb && !bus_sel && bus_we));
endmodule

bind cmd_data_bridge cdb_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .done      (done),
  .rd_valid  (rd_valid),
  .wr_next   (wr_next),
  .bus_stb   (bus_stb),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we)
);

// File: tb/tb_cmd_data_bridge.sv
module tb_cmd_data_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4096;
  localparam int WD = 3000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [7:0]  req_offset = '0;
  logic [15:0] req_wdata = '0;
  logic [11:0] req_len = '0;
  logic        req_ready, done, rd_valid, wr_next, bus_stb, bus_sel, bus_we;
  logic [15:0] rd_data, bus_wdata;
  logic [15:0] bus_rdata = '0;

  cmd_data_bridge dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_offset(req_offset), .req_wdata(req_wdata), .req_len(req_len),
    .req_ready(req_ready), .done(done), .rd_data(rd_data), .rd_valid(rd_valid),
    .wr_next(wr_next), .bus_stb(bus_stb), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit chk_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] pat(input int t);
    return 16'h3C00 ^ (16'(t) * 16'h0107);
  endfunction

  always @(negedge clk) bus_rdata = pat(cyc);

  // expected outputs per absolute cycle
  logic        e_stb [NC], e_sel [NC], e_we [NC], e_rdy [NC], e_done [NC], e_rdv [NC], e_wrn [NC];
  logic [15:0] e_wd [NC], e_rd [NC];
  string       e_tag [NC];

  initial begin
    for (int i = 0; i < NC; i++) begin
      e_stb[i] = 0; e_sel[i] = 0; e_we[i] = 0; e_rdy[i] = 1; e_done[i] = 0;
      e_rdv[i] = 0; e_wrn[i] = 0; e_wd[i] = '0; e_rd[i] = '0; e_tag[i] = "R11";
    end
  end

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && cyc < NC) begin
      chk(e_tag[cyc], "bus_stb", 16'(bus_stb), 16'(e_stb[cyc]));
      chk("R2", "req_ready", 16'(req_ready), 16'(e_rdy[cyc]));
      chk(e_done[cyc] ? e_tag[cyc] : "R12", "done", 16'(done), 16'(e_done[cyc]));
      chk("R9", "rd_valid", 16'(rd_valid), 16'(e_rdv[cyc]));
      chk("R8", "wr_next", 16'(wr_next), 16'(e_wrn[cyc]));
      if (e_stb[cyc]) begin
        chk(e_tag[cyc], "bus_sel", 16'(bus_sel), 16'(e_sel[cyc]));
        chk(e_tag[cyc], "bus_we", 16'(bus_we), 16'(e_we[cyc]));
        if (e_we[cyc]) chk(e_tag[cyc], "bus_wdata", bus_wdata, e_wd[cyc]);
      end
      if (e_rdv[cyc]) chk(e_tag[cyc], "rd_data", rd_data, e_rd[cyc]);
    end
  end

  // builds expectations for a request accepted at the edge closing cycle c; returns the done cycle
  function automatic int sched(input int c, input logic [1:0] op, input logic [7:0] off,
                               input logic [15:0] wd, input logic [11:0] len);
    int fin;
    if (op[1] == 1'b0) begin
      e_stb[c+1] = 1; e_sel[c+1] = 1; e_we[c+1] = 1;
      e_wd[c+1] = ({8'h00, off} & 16'hFFFE) | (off[1] ? 16'hC000 : 16'h3000);
      e_tag[c+1] = off[1] ? "R4" : "R3";
      e_stb[c+3] = 1; e_sel[c+3] = 0; e_we[c+3] = op[0]; e_wd[c+3] = wd;
      e_tag[c+3] = op[0] ? "R6" : "R5";
      fin = c + 4;
      e_rdv[fin] = !op[0]; e_rd[fin] = pat(c + 3);
      e_tag[fin] = op[0] ? "R6" : "R5";
    end else begin
      int n = int'(len) / 2;
      if (n == 0) begin
        fin = c + 1;
        e_tag[fin] = "R10";
      end else begin
        for (int k = 0; k < n; k++) begin
          int t = c + 1 + 2 * k;
          e_stb[t] = 1; e_sel[t] = 0; e_we[t] = op[0];
          e_wd[t] = wd + 16'(k) * 16'h0101;
          e_tag[t] = op[0] ? "R8" : "R7";
          if (!op[0]) begin e_rdv[t+1] = 1; e_rd[t+1] = pat(t); e_tag[t+1] = "R9"; end
          else if (k < n - 1) e_wrn[t+1] = 1;
        end
        fin = c + 2 * n;
        e_tag[fin] = len[0] ? "R10" : (op[0] ? "R8" : "R9");
      end
    end
    for (int t = c + 1; t < fin; t++) e_rdy[t] = 0;
    e_done[fin] = 1;
    return fin;
  endfunction

  // called at a falling edge with the bridge idle; returns at the falling edge of the done cycle
  task automatic do_req(input logic [1:0] op, input logic [7:0] off, input logic [15:0] wd,
                        input logic [11:0] len, input bit junk);
    int c = cyc;
    int fin;
    req_valid = 1; req_op = op; req_offset = off; req_wdata = wd; req_len = len;
    fin = sched(c, op, off, wd, len);
    for (int t = c + 1; t <= fin; t++) begin
      @(negedge clk);
      if (t < fin && junk) begin
        req_valid = 1; req_op = 2'b01; req_offset = 8'h40; req_len = 12'd4;
      end else begin
        req_valid = 0;
      end
      if (op == 2'b11 && ((t - c) % 2 == 0))
        req_wdata = wd + 16'((t - c) / 2) * 16'h0101;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset ready", 16'(req_ready), 16'd1);
    chk("R1", "reset stb", 16'(bus_stb), 16'd0);
    chk("R1", "reset done", 16'(done), 16'd0);
    chk("R1", "reset rd_valid", 16'(rd_valid), 16'd0);
    chk("R1", "reset wr_next", 16'(wr_next), 16'd0);
    rst = 0;
    chk_on = 1;
    repeat (2) @(negedge clk);
    do_req(2'b00, 8'h24, 16'h0000, 12'd0, 0);   // R3 read, low enables
    @(negedge clk);
    do_req(2'b00, 8'h26, 16'h0000, 12'd0, 0);   // R4 read, high enables
    @(negedge clk);
    do_req(2'b01, 8'h92, 16'h2000, 12'd0, 0);   // R6 write, high enables
    do_req(2'b01, 8'h10, 16'h1234, 12'd0, 0);   // R12 back to back on done
    @(negedge clk);
    do_req(2'b00, 8'h11, 16'h0000, 12'd0, 1);   // R3 odd offset, R2 junk while busy
    @(negedge clk);
    do_req(2'b11, 8'h00, 16'hB000, 12'd8, 1);   // R8 four words, R2 junk while busy
    @(negedge clk);
    do_req(2'b10, 8'h00, 16'h0000, 12'd6, 0);   // R9 three words
    do_req(2'b10, 8'h00, 16'h0000, 12'd7, 0);   // R10 odd length
    @(negedge clk);
    do_req(2'b11, 8'h00, 16'hC100, 12'd1, 0);   // R10 below two bytes
    @(negedge clk);
    do_req(2'b10, 8'h00, 16'h0000, 12'd0, 0);   // R10 zero length
    @(negedge clk);
    do_req(2'b11, 8'hFE, 16'h7E00, 12'd2, 0);   // R7 single word
    @(negedge clk);
    do_req(2'b01, 8'hFE, 16'hA5A5, 12'd0, 0);   // R4 top offset
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R12 watchdog: actual no end expected end by cycle %0d", WD);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule